// File: doc/BRIEF.md
# SAR Converter Serial Sequencer

This block is the digital controller of a 12-bit successive-approximation converter that is run over a three-wire serial link: a serial clock, an active-low select and a data input. Each transaction opens with an 8-bit control word. While that word is still arriving, the block starts the track phase on the fourth falling clock edge. It moves the sampling switch into hold on the eighth falling edge. It then runs a binary search of twelve steps, one per serial clock, using a single comparator bit. Each decided bit goes out on a tri-state data line.

The control word sets a two-bit input range code and a polarity bit, which the block latches and presents for the analog front end. It also carries a flag that switches the internal reference buffer off so that an external reference can be used. From the start of tracking to the last result bit, a conversion occupies sixteen serial clocks. If the select line rises at any point, the frame is abandoned.

Top module: `sar_serial_seq`

## Requirements
- R1: `sdo_en` is low whenever `cs_n` is high, and `sdo` is then undriven. While `cs_n` is low, `sdo_en` is high only after the first rising `sclk` edge of a frame whose first bit was 1.
- R2: `din` is sampled on rising `sclk` edges, MSB first. Control bit 1 is the start bit, bits 2–3 are the range code (bit 2 is its MSB), bit 4 selects bipolar (1) or unipolar (0), bit 5 disables the reference (1 = off), and bits 6–8 are ignored. `range_o` shows bits 2–3 after the 8th rising edge.
- R3: A frame whose start bit is 0 is ignored. `trk_o` and `hold_o` stay 0, `sdo_en` stays 0, `trial_o` stays 0, and the latched settings keep their values.
- R4: In a valid frame, `trk_o` rises on the 4th falling `sclk` edge. On the 8th falling edge `trk_o` falls and `hold_o` rises. The two are never high together.
- R5: `hold_o` falls on the 20th falling edge, sixteen clocks after tracking began.
- R6: `trial_o` becomes 0x800 on the 8th rising edge. On rising edge k (9 ≤ k ≤ 20), bit 20−k takes the value of `cmp_i`, and the next lower bit is set as the next trial. After the 20th rising edge `trial_o` holds the result and does not change again in that frame.
- R7: On falling edge k (9 ≤ k ≤ 20), `sdo` carries result bit 20−k, MSB first. At every other time while it is enabled, `sdo` is 0.
- R8: In bipolar mode the first output bit is inverted, so the serial result is two's complement. In unipolar mode it is straight binary.
- R9: `range_o` and `bipolar_o` update only on the 8th rising edge of a valid frame. They keep their values through later frames, aborted or ignored ones included, until the next valid control word.
- R10: `ref_en_o` is the inverse of the reference-disable bit and is latched on the same edge as R9.
- R11: Raising `cs_n` mid-frame at once clears `trk_o`, `hold_o`, `sdo_en` and `trial_o` and restarts the edge count. The next frame runs normally.
- R12: While `rst_n` is low: `trk_o`, `hold_o`, `sdo_en` are 0, `trial_o` is 0, `ref_en_o` is 1, and `range_o` and `bipolar_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; all sequencing follows its edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select; high aborts and idles the frame |
| din | input | 1 | Serial control input, sampled on rising edges |
| cmp_i | input | 1 | Comparator decision: input at or above trial code |
| sdo | output | 1 | Tri-state serial result, changes on falling edges |
| sdo_en | output | 1 | High while `sdo` is driven |
| trk_o | output | 1 | Sampling switch in track phase |
| hold_o | output | 1 | Sampling switch in hold/convert phase |
| trial_o | output | 12 | Trial code for the feedback DAC |
| ref_en_o | output | 1 | Internal reference buffer enable |
| range_o | output | 2 | Latched input range code |
| bipolar_o | output | 1 | Latched polarity: 1 bipolar, 0 unipolar |

## Verification
On every clock the assertions check these properties: track and hold never overlap, and hold starts and ends only on its own edge counts. The first trial code has exactly one bit set, the trial code freezes once the search is done, and the data line stays quiet before the first result bit. The latched settings move only on the control-word edge, and the data line never drives while the select is high. Only the bench scenarios can show that the serial result equals the converted value for a range of comparator thresholds and in both polarities. The same holds for ignored frames leaving all settings untouched and for recovery after an aborted frame.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  // Latched front-end settings, in control-word arrival order.
  typedef struct packed {
    logic [1:0] range;
    logic       bipolar;
    logic       ref_off;
  } sar_cfg_t;

  localparam int CFG_W = $bits(sar_cfg_t);

  // One binary-search step: fix bit pos to keep, then place the next trial bit.
  function automatic logic [31:0] sar_step(input logic [31:0] code, input int pos,
                                           input logic keep);
    logic [31:0] m;
    logic [31:0] r;
    m = 32'd1 << pos;
    r = keep ? (code | m) : (code & ~m);
    if (pos > 0) r = r | (m >> 1);
    return r;
  endfunction

  // Serial output bit: offset binary turned into two's complement by flipping the MSB.
  function automatic logic out_bit(input logic [31:0] code, input int pos,
                                   input int msb, input logic bip);
    logic [31:0] s;
    s = code >> pos;
    return s[0] ^ (bip && (pos == msb));
  endfunction

endpackage

// File: rtl/sar_frame_ctl.sv
module sar_frame_ctl
  import sar_seq_pkg::*;
#(
  parameter int CW_W     = 8,
  parameter int ACQ_EDGE = 4,
  parameter int RES_W    = 12,
  parameter int CNT_W    = 5
) (
  input  logic             sclk,
  input  logic             rst_n,
  input  logic             frame_clr,
  input  logic             din,
  output logic [CNT_W-1:0] cnt_o,
  output logic             frame_ok_o,
  output sar_cfg_t         cfg_o,
  output logic             trk_o,
  output logic             hold_o
);

  localparam logic [CNT_W-1:0] K_ACQ  = CNT_W'(ACQ_EDGE);
  localparam logic [CNT_W-1:0] K_HOLD = CNT_W'(CW_W);
  localparam logic [CNT_W-1:0] K_LAST = CNT_W'(CW_W + RES_W);
  localparam logic [CNT_W-1:0] K_FLD0 = CNT_W'(1);
  localparam logic [CNT_W-1:0] K_FLDN = CNT_W'(CFG_W);
  localparam logic [CNT_W-1:0] K_MAX  = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             ok_q;
  logic [CFG_W-1:0] stage_q;
  sar_cfg_t         cfg_q;
  logic             trk_q, hold_q;
  logic             word_done;

  // Rising-edge counter and field capture; cleared while the frame is idle.
  always_ff @(posedge sclk or posedge frame_clr) begin
    if (frame_clr) begin
      cnt_q   <= '0;
      ok_q    <= 1'b0;
      stage_q <= '0;
    end else begin
      if (cnt_q != K_MAX) cnt_q <= cnt_q + 1'b1;
      if (cnt_q == '0) ok_q <= din;
      if (cnt_q >= K_FLD0 && cnt_q <= K_FLDN) stage_q <= {stage_q[CFG_W-2:0], din};
    end
  end

  // Eighth rising edge of an accepted frame.
  assign word_done = ok_q && (cnt_q == K_HOLD - 1'b1);

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n)         cfg_q <= '0;
    else if (word_done) cfg_q <= sar_cfg_t'(stage_q);
  end

  // Track/hold phases follow falling edges.
  always_ff @(negedge sclk or posedge frame_clr) begin
    if (frame_clr) begin
      trk_q  <= 1'b0;
      hold_q <= 1'b0;
    end else if (ok_q) begin
      if (cnt_q == K_ACQ) trk_q <= 1'b1;
      if (cnt_q == K_HOLD) begin
        trk_q  <= 1'b0;
        hold_q <= 1'b1;
      end
      if (cnt_q == K_LAST) hold_q <= 1'b0;
    end
  end

  assign cnt_o      = cnt_q;
  assign frame_ok_o = ok_q;
  assign cfg_o      = cfg_q;
  assign trk_o      = trk_q;
  assign hold_o     = hold_q;

  assert_th_excl_R4: assert property (@(posedge sclk) disable iff (frame_clr)
    !(trk_q && hold_q));
  assert_hold_start_R4: assert property (@(posedge sclk) disable iff (frame_clr)
    $rose(hold_q) |-> cnt_q == K_HOLD);
  assert_hold_end_R5: assert property (@(posedge sclk) disable iff (frame_clr)
    ($fell(hold_q) && cnt_q != '0) |-> cnt_q == K_LAST);
  assert_cfg_hold_R9: assert property (@(posedge sclk) disable iff (!rst_n)
    !word_done |=> $stable(cfg_q));

endmodule

// File: rtl/sar_engine.sv
module sar_engine
  import sar_seq_pkg::*;
#(
  parameter int CW_W  = 8,
  parameter int RES_W = 12,
  parameter int CNT_W = 5
) (
  input  logic             sclk,
  input  logic             frame_clr,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             frame_ok_i,
  input  logic             cmp_i,
  output logic [RES_W-1:0] trial_o
);

  localparam int               LAST_I = CW_W + RES_W;
  localparam logic [CNT_W-1:0] K_HOLD = CNT_W'(CW_W);
  localparam logic [CNT_W-1:0] K_LAST = CNT_W'(LAST_I);
  localparam logic [RES_W-1:0] MSB_T  = RES_W'(1) << (RES_W - 1);

  logic [RES_W-1:0] trial_q;
  logic             step_now;
  int               step_pos;

  assign step_now = frame_ok_i && (cnt_i >= K_HOLD) && (cnt_i < K_LAST);
  assign step_pos = LAST_I - 1 - int'(cnt_i);

  always_ff @(posedge sclk or posedge frame_clr) begin
    if (frame_clr) begin
      trial_q <= '0;
    end else if (frame_ok_i && cnt_i == K_HOLD - 1'b1) begin
      trial_q <= MSB_T;
    end else if (step_now) begin
      trial_q <= RES_W'(sar_step(32'(trial_q), step_pos, cmp_i));
    end
  end

  assign trial_o = trial_q;

  assert_first_trial_R6: assert property (@(posedge sclk) disable iff (frame_clr)
    (frame_ok_i && cnt_i == K_HOLD) |-> $countones(trial_q) == 1);
  assert_trial_frozen_R6: assert property (@(posedge sclk) disable iff (frame_clr)
    (cnt_i > K_LAST) |-> $stable(trial_q));

endmodule

// File: rtl/sar_dout.sv
module sar_dout
  import sar_seq_pkg::*;
#(
  parameter int CW_W  = 8,
  parameter int RES_W = 12,
  parameter int CNT_W = 5
) (
  input  logic             sclk,
  input  logic             frame_clr,
  input  logic             cs_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             frame_ok_i,
  input  logic             bipolar_i,
  input  logic [RES_W-1:0] trial_i,
  output logic             sdo_q_o,
  output logic             sdo_en_o
);

  localparam int               LAST_I = CW_W + RES_W;
  localparam logic [CNT_W-1:0] K_HOLD = CNT_W'(CW_W);
  localparam logic [CNT_W-1:0] K_LAST = CNT_W'(LAST_I);

  logic sdo_q;
  logic shift_now;
  int   bit_pos;

  assign shift_now = frame_ok_i && (cnt_i > K_HOLD) && (cnt_i <= K_LAST);
  assign bit_pos   = LAST_I - int'(cnt_i);

  always_ff @(negedge sclk or posedge frame_clr) begin
    if (frame_clr)      sdo_q <= 1'b0;
    else if (shift_now) sdo_q <= out_bit(32'(trial_i), bit_pos, RES_W - 1, bipolar_i);
    else                sdo_q <= 1'b0;
  end

  assign sdo_q_o  = sdo_q;
  assign sdo_en_o = frame_ok_i && !cs_n;

  always_comb begin
    if (cs_n === 1'b1) assert_float_R1: assert (!sdo_en_o);
  end

  assert_quiet_R7: assert property (@(posedge sclk) disable iff (frame_clr)
    (cnt_i <= K_HOLD) |-> !sdo_q);

endmodule

// File: rtl/sar_serial_seq.sv
module sar_serial_seq
  import sar_seq_pkg::*;
#(
  parameter int RES_W    = 12,
  parameter int CW_W     = 8,
  parameter int ACQ_EDGE = 4
) (
  input  logic             sclk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             din,
  input  logic             cmp_i,
  output logic             sdo,
  output logic             sdo_en,
  output logic             trk_o,
  output logic             hold_o,
  output logic [RES_W-1:0] trial_o,
  output logic             ref_en_o,
  output logic [1:0]       range_o,
  output logic             bipolar_o
);

  localparam int CNT_W = $clog2(CW_W + RES_W + 2);

  logic             frame_clr;
  logic [CNT_W-1:0] cnt;
  logic             frame_ok;
  sar_cfg_t         cfg;
  logic             sdo_q;

  assign frame_clr = cs_n | ~rst_n;

  sar_frame_ctl #(.CW_W(CW_W), .ACQ_EDGE(ACQ_EDGE), .RES_W(RES_W), .CNT_W(CNT_W)) u_ctl (
    .sclk(sclk), .rst_n(rst_n), .frame_clr(frame_clr), .din(din),
    .cnt_o(cnt), .frame_ok_o(frame_ok), .cfg_o(cfg), .trk_o(trk_o), .hold_o(hold_o)
  );

  sar_engine #(.CW_W(CW_W), .RES_W(RES_W), .CNT_W(CNT_W)) u_eng (
    .sclk(sclk), .frame_clr(frame_clr), .cnt_i(cnt), .frame_ok_i(frame_ok),
    .cmp_i(cmp_i), .trial_o(trial_o)
  );

  sar_dout #(.CW_W(CW_W), .RES_W(RES_W), .CNT_W(CNT_W)) u_out (
    .sclk(sclk), .frame_clr(frame_clr), .cs_n(cs_n), .cnt_i(cnt),
    .frame_ok_i(frame_ok), .bipolar_i(cfg.bipolar), .trial_i(trial_o),
    .sdo_q_o(sdo_q), .sdo_en_o(sdo_en)
  );

  assign sdo       = sdo_en ? sdo_q : 1'bz;
  assign ref_en_o  = ~cfg.ref_off;
  assign range_o   = cfg.range;
  assign bipolar_o = cfg.bipolar;

  assert_reset_R12: assert property (@(posedge sclk) disable iff (rst_n)
    ref_en_o && !bipolar_o && range_o == 2'b00 && trial_o == '0);

endmodule

// File: tb/sar_serial_seq_bench.sv
module sar_serial_seq_bench;

  localparam int CLK_P = 20;
  localparam int Q     = CLK_P / 4;

  logic        sclk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, din = 1'b0;
  logic [11:0] tgt = '0;
  wire         sdo;
  logic        sdo_en, trk, hold, ref_en, bip;
  logic [11:0] trial;
  logic [1:0]  rng;
  logic        cmp;

  int nrun = 0, nfail = 0;
  logic done = 1'b0;
  logic [1:0] exp_rng = 2'b00;
  logic       exp_bip = 1'b0, exp_ref = 1'b1;

  // Comparator model: analog input equals tgt; keep a bit while trial <= input.
  assign cmp = (trial <= tgt);

  sar_serial_seq u_sar_serial_seq (
    .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .din(din), .cmp_i(cmp),
    .sdo(sdo), .sdo_en(sdo_en), .trk_o(trk), .hold_o(hold), .trial_o(trial),
    .ref_en_o(ref_en), .range_o(rng), .bipolar_o(bip)
  );

  // {control word, converted value}
  localparam logic [19:0] VEC [0:6] = '{
    {8'b1_00_0_0_000, 12'hA5C},
    {8'b1_01_1_0_000, 12'h800},
    {8'b1_10_0_1_101, 12'hFFF},
    {8'b0_11_1_0_111, 12'h3C3},
    {8'b1_11_1_0_000, 12'h000},
    {8'b1_00_1_1_000, 12'h7FF},
    {8'b1_10_0_0_010, 12'h001}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nrun++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rise(input logic d);
    din = d;
    #Q sclk = 1'b1;
    #Q;
  endtask

  task automatic fall();
    #Q sclk = 1'b0;
    #Q;
  endtask

  task automatic do_frame(input logic [7:0] cw, input logic [11:0] tg);
    logic ok;
    logic [11:0] ser;
    ok  = cw[7];
    tgt = tg;
    cs_n = 1'b0;
    for (int k = 1; k <= 20; k++) begin
      rise(k <= 8 ? cw[8-k] : 1'b0);
      if (k == 8) begin
        if (ok) begin
          exp_rng = cw[6:5];
          exp_bip = cw[4];
          exp_ref = ~cw[3];
        end
        chk("R2 range", 32'(rng), 32'(exp_rng));
        chk("R9 bipolar", 32'(bip), 32'(exp_bip));
        chk("R10 ref_en", 32'(ref_en), 32'(exp_ref));
        chk("R6 first trial", 32'(trial), ok ? 32'h800 : 32'h0);
      end
      if (k == 20) chk(ok ? "R6 result" : "R3 trial idle", 32'(trial), ok ? 32'(tg) : 32'h0);
      fall();
      ser = tg ^ (exp_bip ? 12'h800 : 12'h000);
      if (!ok && (k == 4 || k == 8 || k == 12))
        chk("R3 ignored", {29'd0, trk, hold, sdo_en}, 32'd0);
      if (ok && k == 3) chk("R7 quiet", {30'd0, sdo_en, sdo}, 32'b10);
      if (ok && k == 4) chk("R4 track", {30'd0, trk, hold}, 32'b10);
      if (ok && k == 8) chk("R4 hold", {30'd0, trk, hold}, 32'b01);
      if (ok && k == 19) chk("R5 still hold", 32'(hold), 32'd1);
      if (ok && k >= 9) chk(k == 9 ? "R8 msb" : "R7 bit", {30'd0, sdo_en, sdo},
                            {30'd0, 1'b1, ser[20-k]});
      if (ok && k == 20) chk("R5 release", 32'(hold), 32'd0);
    end
    cs_n = 1'b1;
    #Q;
    chk("R1 float", {29'd0, sdo_en, trk, hold}, 32'd0);
    #Q;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      nrun++;
      nfail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nrun, nfail);
      $finish;
    end
  end

  initial begin
    #(CLK_P);
    chk("R12 reset", {24'd0, trk, hold, sdo_en, ref_en, rng, bip, 1'b0}, 32'b0001_0000);
    chk("R12 trial", 32'(trial), 32'd0);
    rst_n = 1'b1;
    #(CLK_P);

    for (int i = 0; i < 7; i++) do_frame(VEC[i][19:12], VEC[i][11:0]);

    // R11: abort during hold, then a clean frame.
    tgt  = 12'hABC;
    cs_n = 1'b0;
    for (int k = 1; k <= 10; k++) begin
      rise(k <= 8 ? (8'b1_01_1_0_000 >> (8 - k)) & 1'b1 : 1'b0);
      fall();
    end
    chk("R11 in hold", 32'(hold), 32'd1);
    exp_rng = 2'b01;
    exp_bip = 1'b1;
    exp_ref = 1'b1;
    cs_n = 1'b1;
    #Q;
    chk("R11 abort", {29'd0, trk, hold, sdo_en}, 32'd0);
    chk("R11 trial clear", 32'(trial), 32'd0);
    chk("R9 kept after abort", {30'd0, rng}, 32'b01);
    #Q;
    do_frame(8'b1_11_0_0_000, 12'h5A5);

    // R1: clocks with select high drive nothing.
    for (int k = 0; k < 4; k++) begin
      rise(1'b1);
      fall();
    end
    chk("R1 idle clocks", {29'd0, sdo_en, trk, hold}, 32'd0);

    // R12: reset restores defaults after a reference-off frame.
    do_frame(8'b1_10_1_1_000, 12'h123);
    rst_n = 1'b0;
    #Q;
    chk("R12 reset again", {28'd0, ref_en, rng, bip}, 32'b1000);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nrun, nfail);
    $finish;
  end

endmodule